// File: doc/BRIEF.md
# I2C SCL Duty-Controlled Clock Divider

This block produces the SCL waveform for an I2C master from a fast source clock. A packed control word gives the length of the low phase and, optionally, a separate length for the high phase. With the high field at zero the clock is symmetric, which suits standard-mode rates. With a nonzero high field the two phases are set independently, which gives the roughly one-third high, two-thirds low duty cycle used above 100 kHz. Each programmed count has a fixed offset of three source cycles added to it. The divider values are worked out elsewhere, for example from a 19.2 MHz source. They reach this block already packed into the word.

The bus engine pulses a start request to begin clocking and a stop request to end it. The block returns one-cycle strobes where SCL rises, where it falls, and at the middle of each low phase. The engine uses the mid-low strobe to time its SDA changes. While idle, SCL rests high and the counters stay cleared.

Top module: `scl_duty_gen`

## Requirements
- R1: After reset and whenever busy_o is 0, scl_o is 1 and rise_stb_o, fall_stb_o and mid_stb_o are all 0.
- R2: Each low phase lasts LO+3 source cycles, where LO is the unsigned value of ctl_word bits 7:0.
- R3: When the high field (ctl_word bits 23:16) is 0, each high phase lasts the same LO+3 cycles as the low phase.
- R4: When the high field HI is nonzero, each high phase lasts HI+3 source cycles.
- R5: rise_stb_o is 1 for exactly the first cycle in which scl_o is high after being low, and fall_stb_o for exactly the first cycle in which scl_o is low after being high. scl_o never changes level without one of them.
- R6: mid_stb_o is 1 for one cycle in each low phase, at 0-based cycle index floor((LO+3)/2) counted from the cycle that carries fall_stb_o.
- R7: A start request sampled while idle makes busy_o 1, scl_o 0 and fall_stb_o 1 in the next cycle. A start request while busy has no effect.
- R8: A stop request while busy lets the current or next high phase run to full length. SCL then stays high and busy_o drops to 0 in the cycle after the last high cycle. A stop request while idle has no effect.
- R9: The control word is sampled only when a low phase begins. A change during a period takes effect from the next low phase.
- R10: The high-speed divider field, ctl_word bits 10:8, has no effect on the SCL timing.
- R11: At most one of rise_stb_o, fall_stb_o and mid_stb_o is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_word | input | 24 | Packed divider word: low field 7:0, high-speed field 10:8, high field 23:16 |
| start_req | input | 1 | Begin clocking (one-cycle pulse) |
| stop_req | input | 1 | End clocking after a high phase (one-cycle pulse) |
| scl_o | output | 1 | SCL level |
| busy_o | output | 1 | Clocking in progress |
| rise_stb_o | output | 1 | SCL rising strobe |
| fall_stb_o | output | 1 | SCL falling strobe |
| mid_stb_o | output | 1 | Mid-low strobe for SDA changes |

## Verification
The bench sweeps low fields 0 to 6 against high fields 0, 1, 3 and 5, plus a pair of large values. The zero high field shows whether symmetric mode is taken, and the nonzero fields show whether the high count is decoded separately. Odd and even low lengths check the rounding of the mid-low point. Every run switches the control word after the first fall, which shows whether the word is held for each period. The high-speed field is varied in every case, so a dependence on it would change a measured length. Stray start pulses while running and stray stop pulses while idle test both ignore rules.

// File: rtl/scl_duty_pkg.sv
package scl_duty_pkg;
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } scl_phase_e;

    localparam int unsigned DEF_CTL_W  = 24;
    localparam int unsigned DEF_LO_W   = 8;
    localparam int unsigned DEF_HI_W   = 8;
    localparam int unsigned DEF_HI_LSB = 16;
    localparam int unsigned DEF_OFFSET = 3;
endpackage

// File: rtl/scl_duty_decode.sv
module scl_duty_decode #(
    parameter int unsigned CTL_W  = 24,
    parameter int unsigned LO_W   = 8,
    parameter int unsigned HI_W   = 8,
    parameter int unsigned HI_LSB = 16,
    parameter int unsigned OFFSET = 3,
    parameter int unsigned CNT_W  = 9
) (
    input  logic [CTL_W-1:0] ctl_word,
    output logic [CNT_W-1:0] lo_len,
    output logic [CNT_W-1:0] hi_len
);
    logic [LO_W-1:0] lo_field;
    logic [HI_W-1:0] hi_field;

    always_comb begin
        lo_field = ctl_word[LO_W-1:0];
        hi_field = ctl_word[HI_LSB +: HI_W];
        lo_len   = CNT_W'(lo_field) + CNT_W'(OFFSET);
        if (hi_field == '0) begin
            hi_len = lo_len;
        end else begin
            hi_len = CNT_W'(hi_field) + CNT_W'(OFFSET);
        end
    end
endmodule

// File: rtl/scl_duty_seq.sv
module scl_duty_seq
    import scl_duty_pkg::*;
#(
    parameter int unsigned CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] lo_len_in,
    input  logic [CNT_W-1:0] hi_len_in,
    input  logic             start_req,
    input  logic             stop_req,
    output logic             scl_o,
    output logic             busy_o,
    output logic             rise_stb_o,
    output logic             fall_stb_o,
    output logic             mid_stb_o
);
    typedef struct packed {
        logic             run;
        scl_phase_e       phase;
        logic [CNT_W-1:0] cnt;
        logic             scl;
        logic             rise;
        logic             fall;
        logic             mid;
        logic             stop_pend;
        logic [CNT_W-1:0] lo_len;
        logic [CNT_W-1:0] hi_len;
    } seq_state_t;

    localparam seq_state_t RESET_ST = '{
        run: 1'b0, phase: PH_LOW, cnt: '0, scl: 1'b1, rise: 1'b0,
        fall: 1'b0, mid: 1'b0, stop_pend: 1'b0, lo_len: '0, hi_len: '0
    };

    seq_state_t st_d, st_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             lo_last, hi_last;

    always_comb begin
        st_d    = st_q;
        st_d.rise = 1'b0;
        st_d.fall = 1'b0;
        st_d.mid  = 1'b0;
        cnt_inc = st_q.cnt + 1'b1;
        lo_last = (st_q.cnt == st_q.lo_len - 1'b1);
        hi_last = (st_q.cnt == st_q.hi_len - 1'b1);

        if (!st_q.run) begin
            st_d.cnt       = '0;
            st_d.scl       = 1'b1;
            st_d.stop_pend = 1'b0;
            st_d.phase     = PH_LOW;
            if (start_req) begin
                st_d.run    = 1'b1;
                st_d.scl    = 1'b0;
                st_d.fall   = 1'b1;
                st_d.lo_len = lo_len_in;
                st_d.hi_len = hi_len_in;
            end
        end else begin
            if (stop_req) begin
                st_d.stop_pend = 1'b1;
            end
            if (st_q.phase == PH_LOW) begin
                if (lo_last) begin
                    st_d.phase = PH_HIGH;
                    st_d.cnt   = '0;
                    st_d.scl   = 1'b1;
                    st_d.rise  = 1'b1;
                end else begin
                    st_d.cnt = cnt_inc;
                    st_d.mid = (cnt_inc == (st_q.lo_len >> 1));
                end
            end else begin
                if (hi_last) begin
                    st_d.cnt = '0;
                    if (st_q.stop_pend || stop_req) begin
                        st_d.run       = 1'b0;
                        st_d.stop_pend = 1'b0;
                        st_d.phase     = PH_LOW;
                    end else begin
                        st_d.phase  = PH_LOW;
                        st_d.scl    = 1'b0;
                        st_d.fall   = 1'b1;
                        st_d.lo_len = lo_len_in;
                        st_d.hi_len = hi_len_in;
                    end
                end else begin
                    st_d.cnt = cnt_inc;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= RESET_ST;
        end else begin
            st_q <= st_d;
        end
    end

    assign scl_o      = st_q.scl;
    assign busy_o     = st_q.run;
    assign rise_stb_o = st_q.rise;
    assign fall_stb_o = st_q.fall;
    assign mid_stb_o  = st_q.mid;
endmodule

// File: rtl/scl_duty_gen.sv
module scl_duty_gen
    import scl_duty_pkg::*;
#(
    parameter int unsigned CTL_W  = DEF_CTL_W,
    parameter int unsigned LO_W   = DEF_LO_W,
    parameter int unsigned HI_W   = DEF_HI_W,
    parameter int unsigned HI_LSB = DEF_HI_LSB,
    parameter int unsigned OFFSET = DEF_OFFSET
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CTL_W-1:0] ctl_word,
    input  logic             start_req,
    input  logic             stop_req,
    output logic             scl_o,
    output logic             busy_o,
    output logic             rise_stb_o,
    output logic             fall_stb_o,
    output logic             mid_stb_o
);
    localparam int unsigned FIELD_W = (LO_W > HI_W) ? LO_W : HI_W;
    localparam int unsigned CNT_W   = FIELD_W + 1;

    logic [CNT_W-1:0] lo_len, hi_len;

    scl_duty_decode #(
        .CTL_W(CTL_W), .LO_W(LO_W), .HI_W(HI_W),
        .HI_LSB(HI_LSB), .OFFSET(OFFSET), .CNT_W(CNT_W)
    ) decode_i (
        .ctl_word(ctl_word),
        .lo_len  (lo_len),
        .hi_len  (hi_len)
    );

    scl_duty_seq #(.CNT_W(CNT_W)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lo_len_in (lo_len),
        .hi_len_in (hi_len),
        .start_req (start_req),
        .stop_req  (stop_req),
        .scl_o     (scl_o),
        .busy_o    (busy_o),
        .rise_stb_o(rise_stb_o),
        .fall_stb_o(fall_stb_o),
        .mid_stb_o (mid_stb_o)
    );
endmodule

// File: rtl/scl_duty_gen_chk.sv
module scl_duty_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_o,
    input logic busy_o,
    input logic rise_stb_o,
    input logic fall_stb_o,
    input logic mid_stb_o
);
    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (scl_o && !rise_stb_o && !fall_stb_o && !mid_stb_o));

    assert_rise_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb_o |-> (scl_o && !$past(scl_o)));

    assert_fall_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb_o |-> (!scl_o && $past(scl_o)));

    assert_edge_has_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_o != $past(scl_o)) |-> (rise_stb_o || fall_stb_o));

    assert_mid_in_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mid_stb_o |-> (!scl_o && busy_o));

    assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_stb_o, fall_stb_o, mid_stb_o}));
endmodule

bind scl_duty_gen scl_duty_gen_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_o     (scl_o),
    .busy_o    (busy_o),
    .rise_stb_o(rise_stb_o),
    .fall_stb_o(fall_stb_o),
    .mid_stb_o (mid_stb_o)
);

// File: tb/scl_duty_gen_tb.sv
module scl_duty_gen_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] ctl_word = '0;
    logic        start_req = 1'b0;
    logic        stop_req = 1'b0;
    logic        scl_o, busy_o, rise_stb_o, fall_stb_o, mid_stb_o;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scl_duty_gen dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_word(ctl_word),
        .start_req(start_req), .stop_req(stop_req),
        .scl_o(scl_o), .busy_o(busy_o), .rise_stb_o(rise_stb_o),
        .fall_stb_o(fall_stb_o), .mid_stb_o(mid_stb_o)
    );

    function automatic logic [23:0] pack(int lo, int hi, int hs);
        return {8'(hi), 5'b0, 3'(hs), 8'(lo)};
    endfunction

    function automatic int exp_hi(int lo, int hi);
        return (hi == 0) ? lo + 3 : hi + 3;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Enters in the first cycle of a phase (sampled after a negedge); leaves in
    // the first cycle that is no longer part of it.
    task automatic measure(input bit lvl, input bit p_start, input bit p_stop,
                           output int len, output int midpos);
        len = 1;
        midpos = -1;
        start_req = p_start;
        stop_req = p_stop;
        forever begin
            @(negedge clk);
            start_req = 1'b0;
            stop_req = 1'b0;
            if (busy_o && scl_o == lvl) begin
                len++;
                if (mid_stb_o) midpos = len - 1;
            end else begin
                break;
            end
        end
    endtask

    task automatic run_case(int lo1, int hi1, int hs1, int lo2, int hi2, int hs2);
        int len, midpos;
        ctl_word = pack(lo1, hi1, hs1);
        @(negedge clk);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        chk(fall_stb_o && !scl_o && busy_o, "R7 start gives fall", int'(fall_stb_o), 1);
        ctl_word = pack(lo2, hi2, hs2); // R9: must not affect the current period
        measure(1'b0, 1'b0, 1'b0, len, midpos);
        chk(len == lo1 + 3, "R2 low length", len, lo1 + 3);
        chk(midpos == (lo1 + 3) / 2, "R6 mid-low position", midpos, (lo1 + 3) / 2);
        chk(rise_stb_o && scl_o, "R5 rise strobe", int'(rise_stb_o), 1);
        measure(1'b1, 1'b1, 1'b0, len, midpos); // R7: start while busy ignored
        chk(len == exp_hi(lo1, hi1), (hi1 == 0) ? "R3 symmetric high length" : "R4 high length (R10 hs varied)",
            len, exp_hi(lo1, hi1));
        chk(fall_stb_o && !scl_o && busy_o, "R5 fall strobe", int'(fall_stb_o), 1);
        measure(1'b0, 1'b0, 1'b1, len, midpos);
        chk(len == lo2 + 3, "R9 new low length", len, lo2 + 3);
        chk(midpos == (lo2 + 3) / 2, "R6 mid-low after change", midpos, (lo2 + 3) / 2);
        measure(1'b1, 1'b0, 1'b0, len, midpos);
        chk(len == exp_hi(lo2, hi2), "R8 last high full length", len, exp_hi(lo2, hi2));
        chk(!busy_o && scl_o, "R8 idle after stop", int'(busy_o), 0);
        repeat (3) begin
            @(negedge clk);
            chk(scl_o && !busy_o && !rise_stb_o && !fall_stb_o && !mid_stb_o,
                "R1 idle quiet", int'(scl_o), 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(scl_o && !busy_o && !rise_stb_o && !fall_stb_o && !mid_stb_o,
            "R1 reset state", int'(scl_o), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(scl_o && !busy_o, "R1 after reset", int'(busy_o), 0);

        // R8: stop while idle must not cut the next run short
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        run_case(2, 1, 0, 2, 1, 0);

        for (int lo = 0; lo < 7; lo++) begin
            for (int h = 0; h < 4; h++) begin
                int hi;
                hi = (h == 0) ? 0 : (2 * h - 1);
                // R10: high-speed field changes with every case
                run_case(lo, hi, (lo + h) % 8, (lo + 3) % 7, (hi + 2) % 6, 7 - (lo % 8));
            end
        end
        run_case(40, 20, 3, 17, 0, 5);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule